// File: doc/BRIEF.md
# Codec Clock and Reset Sequencer

This block sits between the master clock pins and the echo-canceller core. From a 19.2 MHz master clock it makes the serial bit clock (256 kHz) and the frame sync (8 kHz) that the codec and the core's serial ports use. It also decides when the core may process samples and when the serial outputs may drive. It does this by sequencing the external reset and the external power-down request.

Reset and power-down act on the block in different ways. While reset is held, the generated clocks keep running. The serial outputs are released and processing stops. When reset is removed, processing waits through a fixed settling time before it starts. Power-down stops the generated clocks as well. After power-down ends, the block waits for a new reset before it resumes.

The mode pins are sampled only at frame starts. A mode change therefore never lands in the middle of a frame. The core receives a one-cycle pulse to clear its filter coefficients when the pass-through mode is first latched.

Top module: `codec_clk_seq`

## Requirements
- R1: After power-down ends (`pdn_n_i` low to high), the first rising edge of `bclk_o` comes at the third rising edge of `clk_i`. From then on, `bclk_o` repeats with a period of 75 master-clock cycles: 37 cycles high, then 38 cycles low.
- R2: `fsync_o` is high for exactly one bit-clock period (75 cycles) in every 32 bit-clock periods (2400 cycles). It rises and falls on the same edges at which `bclk_o` rises. The first frame starts together with the first bit-clock rise after power-down.
- R3: While `rst_n_i` is low, `bclk_o` and `fsync_o` keep their timing without a break, even when reset is asserted in the middle of a phase. `proc_en_o`, `sout_oe_o` and `rout_oe_o` are low. Reset takes effect asynchronously.
- R4: After `rst_n_i` rises, `proc_en_o`, `sout_oe_o` and `rout_oe_o` go high at rising edge number 1922 of `clk_i`: 2 synchronizer edges plus 1920 settling cycles, which is 100 µs at 19.2 MHz. At edge 1921 they are still low.
- R5: `mode_q_o` loads `mode_i` only at the clock edge where a frame starts (the same edge at which `fsync_o` rises), and only while processing is enabled. Between frame starts it holds its value whatever `mode_i` does. Reset clears it to 0 at once. No value is loaded during the settling time.
- R6: `coef_clr_o` is high for exactly one cycle: the cycle in which the pass-through bit of `mode_q_o` (bit 1) changes from 0 to 1. In every other cycle it is low. A frame start that keeps the bit at 1 gives no pulse.
- R7: When `pdn_n_i` goes low, `bclk_o` and `fsync_o` go low at once, without waiting for a clock edge. `proc_en_o` and both output enables are low from the next rising edge. While power-down lasts, `mode_q_o` ignores `mode_i`.
- R8: After power-down ends, `proc_en_o` and both output enables stay low, and `mode_q_o` stays unchanged, until a reset is applied and its settling time has passed. The generated clocks restart with a fresh frame, as given in R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock (19.2 MHz) |
| rst_n_i | input | 1 | Reset, active low, asynchronous assertion |
| pdn_n_i | input | 1 | Power-down request, active low |
| mode_i | input | 6 | Mode pins; bit 1 is pass-through |
| bclk_o | output | 1 | Generated serial bit clock |
| fsync_o | output | 1 | Generated frame sync, one bit period wide |
| sout_oe_o | output | 1 | Drive enable for the send-side serial output |
| rout_oe_o | output | 1 | Drive enable for the receive-side serial output |
| proc_en_o | output | 1 | Processing enable for the core |
| mode_q_o | output | 6 | Mode pins as latched at the last frame start |
| coef_clr_o | output | 1 | One-cycle coefficient-clear pulse |

## Verification
The bench measures the bit-clock and sync run lengths right after power-down ends. It measures them again across a reset that is asserted partway through a high phase. A divider that restarted on reset, or that was off by one in either phase, would give a run other than 37 or 38. The settling window is counted edge by edge from the release of reset. A counter or synchronizer that is one stage short or one stage long moves the enable by a cycle. Random mode changes in mid-frame, together with a fixed pattern for the pass-through bit at frame starts, expose a latch that follows its pins between frame starts, and a clear that pulses on a level rather than a rising edge. The bench also applies a power-down, then releases it without a reset. This catches a sequencer that resumes processing without the reset it needs.

// File: rtl/ccs_pkg.sv
package ccs_pkg;

  typedef enum logic [1:0] {
    ST_SETTLE = 2'd0,
    ST_RUN    = 2'd1,
    ST_PDOWN  = 2'd2,
    ST_WAIT   = 2'd3
  } seq_st_e;

  // Modulo counter step: wraps to zero after the last value.
  function automatic int unsigned wrap_inc(input int unsigned v, input int unsigned last);
    return (v >= last) ? 0 : v + 1;
  endfunction

  // Bit-clock level for a position inside one bit period.
  function automatic logic bclk_level(input int unsigned pos, input int unsigned hi_len);
    return pos < hi_len;
  endfunction

endpackage

// File: rtl/ccs_sync_assert.sv
module ccs_sync_assert #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic async_n_i,
  output logic active_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge async_n_i) begin
    if (!async_n_i) chain_q <= '1;
    else            chain_q <= chain_q << 1;
  end

  assign active_o = chain_q[STAGES-1];

  // R4: the release only follows a released input.
  a_r4_clean_release: assert property (@(posedge clk_i) disable iff (!async_n_i)
    $fell(active_o) |-> $past(async_n_i));

endmodule

// File: rtl/ccs_bitclk_div.sv
module ccs_bitclk_div
  import ccs_pkg::*;
#(
  parameter int DIV_HI     = 37,
  parameter int DIV_LO     = 38,
  parameter int FRAME_BITS = 32
) (
  input  logic clk_i,
  input  logic pd_i,
  output logic bclk_o,
  output logic fsync_o,
  output logic frame_start_o
);
  localparam int DIV = DIV_HI + DIV_LO;
  localparam int CW  = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int BW  = (FRAME_BITS > 1) ? $clog2(FRAME_BITS) : 1;

  logic [CW-1:0] pos_q, pos_nx;
  logic [BW-1:0] bit_q, bit_nx;
  logic          wrap_w;
  logic          bclk_q, fsync_q;

  always_comb begin
    wrap_w        = (pos_q == CW'(DIV - 1));
    pos_nx        = CW'(wrap_inc(int'(pos_q), DIV - 1));
    bit_nx        = wrap_w ? BW'(wrap_inc(int'(bit_q), FRAME_BITS - 1)) : bit_q;
    frame_start_o = wrap_w && (bit_q == BW'(FRAME_BITS - 1)) && !pd_i;
  end

  // Parked at the last position so that the first active edge opens a frame.
  always_ff @(posedge clk_i or posedge pd_i) begin
    if (pd_i) begin
      pos_q   <= CW'(DIV - 1);
      bit_q   <= BW'(FRAME_BITS - 1);
      bclk_q  <= 1'b0;
      fsync_q <= 1'b0;
    end else begin
      pos_q   <= pos_nx;
      bit_q   <= bit_nx;
      bclk_q  <= bclk_level(int'(pos_nx), DIV_HI);
      fsync_q <= (bit_nx == '0);
    end
  end

  assign bclk_o  = bclk_q;
  assign fsync_o = fsync_q;

  // R2: sync edges line up with bit-clock rises.
  a_r2_fsync_rise_on_bclk: assert property (@(posedge clk_i) disable iff (pd_i)
    $rose(fsync_o) |-> $rose(bclk_o));
  a_r2_fsync_fall_on_bclk: assert property (@(posedge clk_i) disable iff (pd_i)
    $fell(fsync_o) |-> $rose(bclk_o));

endmodule

// File: rtl/ccs_sequencer.sv
module ccs_sequencer
  import ccs_pkg::*;
#(
  parameter int HOLDOFF    = 1920,
  parameter int MODE_W     = 6,
  parameter int BYPASS_IDX = 1
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              pd_i,
  input  logic              frame_start_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic              run_o,
  output logic [MODE_W-1:0] mode_q_o,
  output logic              coef_clr_o
);
  localparam int HW = (HOLDOFF > 1) ? $clog2(HOLDOFF) : 1;

  seq_st_e           state_q, state_nx;
  logic [HW-1:0]     hold_q, hold_nx;
  logic              settle_done_w, latch_w, byp_rise_w;
  logic              run_q, clr_q;
  logic [MODE_W-1:0] mode_q;

  always_comb begin
    settle_done_w = (state_q == ST_SETTLE) && (hold_q == HW'(HOLDOFF - 1));
    latch_w       = frame_start_i && (state_q == ST_RUN) && !pd_i;
    byp_rise_w    = latch_w && mode_i[BYPASS_IDX] && !mode_q[BYPASS_IDX];
    hold_nx       = hold_q;
    state_nx      = state_q;
    case (state_q)
      ST_SETTLE: begin
        if (settle_done_w) state_nx = ST_RUN;
        else               hold_nx  = hold_q + 1'b1;
      end
      ST_PDOWN:  if (!pd_i) state_nx = ST_WAIT;
      default:   ;
    endcase
    if (pd_i) state_nx = ST_PDOWN;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      state_q <= ST_SETTLE;
      hold_q  <= '0;
      run_q   <= 1'b0;
      mode_q  <= '0;
      clr_q   <= 1'b0;
    end else begin
      state_q <= state_nx;
      hold_q  <= hold_nx;
      run_q   <= (state_nx == ST_RUN);
      clr_q   <= byp_rise_w;
      if (latch_w) mode_q <= mode_i;
    end
  end

  assign run_o      = run_q;
  assign mode_q_o   = mode_q;
  assign coef_clr_o = clr_q;

  // R5: latched modes move only right after a frame start.
  a_r5_mode_hold: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !frame_start_i |=> $stable(mode_q_o));
  // R6: the clear is a single-cycle pulse with the bypass bit latched.
  a_r6_clr_single: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    coef_clr_o |=> !coef_clr_o);
  a_r6_clr_with_bypass: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    coef_clr_o |-> mode_q_o[BYPASS_IDX]);
  // R4: processing starts only out of the settling state.
  a_r4_start_from_settle: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $rose(run_o) |-> ($past(state_q) == ST_SETTLE));
  // R7: power-down drops processing on the next edge.
  a_r7_pd_stops: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    pd_i |=> !run_o);
  // R8: without a reset, the waiting state never resumes processing.
  a_r8_wait_for_reset: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (state_q == ST_WAIT) |=> !run_o);

endmodule

// File: rtl/codec_clk_seq.sv
module codec_clk_seq
  import ccs_pkg::*;
#(
  parameter int DIV_HI      = 37,
  parameter int DIV_LO      = 38,
  parameter int FRAME_BITS  = 32,
  parameter int HOLDOFF     = 1920,
  parameter int SYNC_STAGES = 2,
  parameter int MODE_W      = 6,
  parameter int BYPASS_IDX  = 1
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              pdn_n_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic              bclk_o,
  output logic              fsync_o,
  output logic              sout_oe_o,
  output logic              rout_oe_o,
  output logic              proc_en_o,
  output logic [MODE_W-1:0] mode_q_o,
  output logic              coef_clr_o
);
  logic rst_act_w, pd_act_w, rst_s_n_w, frame_start_w, run_w;

  ccs_sync_assert #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk_i     (clk_i),
    .async_n_i (rst_n_i),
    .active_o  (rst_act_w)
  );

  ccs_sync_assert #(.STAGES(SYNC_STAGES)) u_pd_sync (
    .clk_i     (clk_i),
    .async_n_i (pdn_n_i),
    .active_o  (pd_act_w)
  );

  assign rst_s_n_w = !rst_act_w;

  ccs_bitclk_div #(
    .DIV_HI     (DIV_HI),
    .DIV_LO     (DIV_LO),
    .FRAME_BITS (FRAME_BITS)
  ) u_div (
    .clk_i         (clk_i),
    .pd_i          (pd_act_w),
    .bclk_o        (bclk_o),
    .fsync_o       (fsync_o),
    .frame_start_o (frame_start_w)
  );

  ccs_sequencer #(
    .HOLDOFF    (HOLDOFF),
    .MODE_W     (MODE_W),
    .BYPASS_IDX (BYPASS_IDX)
  ) u_seq (
    .clk_i         (clk_i),
    .rst_n_i       (rst_s_n_w),
    .pd_i          (pd_act_w),
    .frame_start_i (frame_start_w),
    .mode_i        (mode_i),
    .run_o         (run_w),
    .mode_q_o      (mode_q_o),
    .coef_clr_o    (coef_clr_o)
  );

  assign proc_en_o = run_w;
  assign sout_oe_o = run_w;
  assign rout_oe_o = run_w;

  // R3: reset keeps the outputs released.
  a_r3_quiet_in_reset: assert property (@(posedge clk_i) disable iff (pd_act_w)
    rst_act_w |-> !sout_oe_o && !rout_oe_o);

endmodule

// File: tb/tb_codec_clk_seq.sv
module tb_codec_clk_seq;
  localparam int HALF    = 4;
  localparam int HI_LEN  = 37;
  localparam int LO_LEN  = 38;
  localparam int NBITS   = 32;
  localparam int HOLD    = 1920;
  localparam int SYNCS   = 2;
  localparam int BYP     = 1;
  localparam int WD_CYC  = 150000;

  logic       clk = 1'b0;
  logic       rst_n, pdn_n;
  logic [5:0] mode;
  logic       bclk, fsync, soe, roe, pen, clr;
  logic [5:0] mode_q;

  int n_checks = 0;
  int n_err    = 0;
  logic [5:0] cur      = '0;
  logic [5:0] exp_mode = '0;
  logic [7:0] byp_pat  = 8'b0110_1101;
  int         pat_idx  = 0;

  always #HALF clk = ~clk;

  codec_clk_seq dut (
    .clk_i(clk), .rst_n_i(rst_n), .pdn_n_i(pdn_n), .mode_i(mode),
    .bclk_o(bclk), .fsync_o(fsync), .sout_oe_o(soe), .rout_oe_o(roe),
    .proc_en_o(pen), .mode_q_o(mode_q), .coef_clr_o(clr)
  );

  function automatic int exp_period();      return HI_LEN + LO_LEN;              endfunction
  function automatic int exp_frame();       return exp_period() * NBITS;         endfunction
  function automatic int exp_start_edges(); return SYNCS + HOLD;                 endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic run_len(input logic lvl, input bit use_fs, output int n);
    n = 0;
    while (((use_fs ? fsync : bclk) == lvl) && n < 5000) begin
      n++;
      step();
    end
  endtask

  task automatic holdoff_check(input string tag);
    int  n = 0;
    int  bad = 0;
    rst_n = 1'b1;
    while (!pen && n < HOLD + 20) begin
      step();
      n++;
      if (!pen && (soe || roe)) bad++;
      if (mode_q != 6'd0) bad++;
      if (n % 97 == 0) begin cur = 6'($urandom); mode = cur; end
    end
    chk(n == exp_start_edges(), tag, "edges to processing enable", n, exp_start_edges());
    chk(soe && roe, tag, "output enables with processing", {soe, roe}, 3);
    chk(bad == 0, "R5", "no mode load / no drive during settling", bad, 0);
  endtask

  task automatic run_frames(input int nframes);
    logic prev_fs = fsync;
    int   frames = 0;
    logic fs_rise, e_clr;
    while (frames < nframes) begin
      step();
      fs_rise = fsync && !prev_fs;
      prev_fs = fsync;
      e_clr   = 1'b0;
      if (fs_rise) begin
        e_clr    = cur[BYP] && !exp_mode[BYP];
        exp_mode = cur;
        frames++;
      end
      chk(mode_q == exp_mode, "R5", "latched mode", int'(mode_q), int'(exp_mode));
      chk(clr == e_clr, "R6", "coefficient clear", int'(clr), int'(e_clr));
      if (fs_rise) begin
        cur      = 6'($urandom);
        cur[BYP] = byp_pat[pat_idx % 8];
        pat_idx++;
        mode = cur;
      end else if ($urandom % 500 == 0) begin
        cur  = 6'($urandom);
        mode = cur;
      end
    end
  endtask

  initial begin
    #(WD_CYC * 2 * HALF);
    n_checks++;
    n_err++;
    $display("FAIL watchdog: actual %0d expected %0d", WD_CYC, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    int n, bad;
    logic [5:0] held;
    void'($urandom(32'd1234));
    pdn_n = 1'b0;
    rst_n = 1'b0;
    mode  = '0;
    repeat (5) step();
    chk(!bclk && !fsync, "R7", "clocks low in power-down", {bclk, fsync}, 0);
    chk(!pen && !soe && !roe, "R3", "idle outputs in reset", {pen, soe, roe}, 0);
    chk(mode_q == 6'd0, "R5", "mode cleared by reset", int'(mode_q), 0);

    // Power-down ends while reset is still held.
    pdn_n = 1'b1;
    step(); step();
    chk(!bclk, "R1", "bclk low at second edge", int'(bclk), 0);
    step();
    chk(bclk && fsync, "R1", "first bclk rise opens a frame", {bclk, fsync}, 3);
    run_len(1'b1, 1'b0, n);
    chk(n == HI_LEN, "R1", "bclk high length", n, HI_LEN);
    run_len(1'b0, 1'b0, n);
    chk(n == LO_LEN, "R1", "bclk low length", n, LO_LEN);
    while (!fsync) step();
    run_len(1'b1, 1'b1, n);
    chk(n == exp_period(), "R2", "fsync high length", n, exp_period());
    run_len(1'b0, 1'b1, n);
    chk(n == exp_frame() - exp_period(), "R2", "fsync low length", n, exp_frame() - exp_period());
    chk(bclk, "R2", "fsync rises with bclk", int'(bclk), 1);
    chk(!pen && !soe && !roe, "R3", "no processing while reset held", {pen, soe, roe}, 0);

    holdoff_check("R4");
    run_frames(12);

    // Power-down during processing.
    pdn_n = 1'b0;
    #1;
    chk(!bclk && !fsync, "R7", "clocks drop at once", {bclk, fsync}, 0);
    step();
    chk(!pen && !soe && !roe, "R7", "processing off after one edge", {pen, soe, roe}, 0);
    held = mode_q;
    bad = 0;
    repeat (200) begin
      mode = 6'($urandom);
      step();
      if (mode_q != held || bclk || fsync) bad++;
    end
    chk(bad == 0, "R7", "modes and clocks frozen in power-down", bad, 0);

    // Release without reset.
    pdn_n = 1'b1;
    step(); step(); step();
    chk(bclk && fsync, "R8", "clocks restart with fresh frame", {bclk, fsync}, 3);
    bad = 0;
    repeat (3000) begin
      if (pen || soe || roe || mode_q != held) bad++;
      mode = 6'($urandom);
      step();
    end
    chk(bad == 0, "R8", "stays idle until reset", bad, 0);

    // Reset asserted inside a high phase of the bit clock.
    while (bclk) step();
    while (!bclk) step();
    n = 0;
    while (bclk && n < 5000) begin
      n++;
      if (n == 11) begin
        rst_n = 1'b0;
        #1;
        chk(mode_q == 6'd0, "R5", "reset clears latched modes", int'(mode_q), 0);
      end
      step();
    end
    chk(n == HI_LEN, "R3", "bclk high length across reset", n, HI_LEN);
    run_len(1'b0, 1'b0, n);
    chk(n == LO_LEN, "R3", "bclk low length in reset", n, LO_LEN);
    chk(!pen && !soe && !roe, "R3", "idle outputs in reset", {pen, soe, roe}, 0);

    exp_mode = '0;
    holdoff_check("R4");
    cur = mode;
    run_frames(5);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

endmodule